// File: doc/BRIEF.md
# Nine-Pixel Median Pipeline

This block takes a 3x3 window of nine unsigned pixels and returns its middle value. It is meant for removing impulse noise from an image stream. The result comes from a fixed schedule of 19 compare-exchange elements. This schedule only guarantees that the middle slot ends up holding the median. It does not produce a fully sorted window.

The schedule is split into nine register stages. Each stage holds exchanges that touch disjoint slots, and each keeps the order the schedule needs. A new window can be accepted on every clock. A valid bit travels beside the data, so the result valid appears a fixed number of cycles after the window valid. The caller presents each window already assembled, with the pixel in slot k on bits [k*PIX_W +: PIX_W].

Top module: `median9_net`

## Requirements
- R1: When `med_vld_o` is high, `med_pix_o` equals the median of the nine pixels of the window. This is the value that has at most four window pixels strictly below it and at most four strictly above it.
- R2: Pixels are compared as unsigned numbers. A pixel of 255 (all ones) ranks above 0 and above 128, and the result always lies between the smallest and largest pixel of its window.
- R3: A window presented with `win_vld_i` high at rising edge k produces `med_vld_o` high with its result after rising edge k+8. That is a latency of nine edges, counting the edge that samples the window.
- R4: Windows presented on consecutive cycles give results on consecutive cycles, in the same order, one per clock.
- R5: Windows that contain repeated values still give the correct median. A window of nine equal pixels returns that pixel.
- R6: While `rst_ni` is low, `med_vld_o` is low. Windows in flight when reset is asserted produce no result after reset is released.
- R7: A cycle with `win_vld_i` low produces no result: `med_vld_o` is low nine edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the valid pipeline |
| win_vld_i | input | 1 | Window valid |
| win_pix_i | input | 9*PIX_W | Nine pixels, slot k on bits [k*PIX_W +: PIX_W] |
| med_vld_o | output | 1 | Result valid |
| med_pix_o | output | PIX_W | Median pixel |

## Verification
Two things can happen in the same cycle. The block can accept a new window while it emits the result of a window sampled nine edges earlier. Reset can also arrive while several windows are still inside the stages. The bench streams sorted, reversed, extreme-value, duplicate-heavy and random windows back to back. It inserts bubbles between them, so input and output overlap in every pattern. A scoreboard queue records, for each window, the expected median and the exact cycle it is due. Reset is also pulled in the middle of a burst. The queue is then flushed, and any valid result that appears afterwards is reported as an error.

// File: rtl/median9_pkg.sv
`timescale 1ns/1ps
package median9_pkg;
  localparam int unsigned NPIX = 9;
  localparam int unsigned MID  = 4;
  localparam int unsigned NXCH = 19;
  localparam int unsigned NSTG = 9;

  // exchange e: slot XLO[e] receives the smaller, XHI[e] the larger value
  localparam int unsigned XLO [NXCH] = '{1, 4, 7, 0, 3, 6, 1, 4, 7, 0, 5, 4, 3, 1, 2, 4, 4, 6, 4};
  localparam int unsigned XHI [NXCH] = '{2, 5, 8, 1, 4, 7, 2, 5, 8, 3, 8, 7, 6, 4, 5, 7, 2, 4, 2};
  // pipeline stage of each exchange; exchanges sharing a stage touch disjoint slots
  localparam int unsigned XSTG[NXCH] = '{0, 0, 0, 1, 1, 1, 2, 2, 2, 3, 3, 3, 4, 4, 4, 5, 6, 7, 8};
endpackage

// File: rtl/median9_cmpx.sv
`timescale 1ns/1ps
module median9_cmpx #(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] a_i,
  input  logic [PIX_W-1:0] b_i,
  output logic [PIX_W-1:0] lo_o,
  output logic [PIX_W-1:0] hi_o
);
  logic swap;
  assign swap = a_i > b_i;  // equal values pass straight through
  assign lo_o = swap ? b_i : a_i;
  assign hi_o = swap ? a_i : b_i;
endmodule

// File: rtl/median9_stage.sv
`timescale 1ns/1ps
module median9_stage
  import median9_pkg::*;
#(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned STG      = 0,
  parameter bit          KEEP_ALL = 1'b1,
  localparam int unsigned BUS_W   = NPIX * PIX_W,
  localparam int unsigned OUT_W   = KEEP_ALL ? BUS_W : PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [BUS_W-1:0] pix_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] pix_o
);
  logic [PIX_W-1:0] win  [NPIX];
  logic [PIX_W-1:0] nxt  [NPIX];
  logic [PIX_W-1:0] lo_w [NXCH];
  logic [PIX_W-1:0] hi_w [NXCH];

  always_comb begin
    for (int k = 0; k < NPIX; k++) win[k] = pix_i[k*PIX_W +: PIX_W];
  end

  for (genvar e = 0; e < NXCH; e++) begin : g_xch
    if (XSTG[e] == STG) begin : g_on
      median9_cmpx #(.PIX_W(PIX_W)) u_cmpx (
        .a_i  (win[XLO[e]]),
        .b_i  (win[XHI[e]]),
        .lo_o (lo_w[e]),
        .hi_o (hi_w[e])
      );
    end else begin : g_off
      assign lo_w[e] = '0;
      assign hi_w[e] = '0;
    end
  end

  always_comb begin
    for (int k = 0; k < NPIX; k++) nxt[k] = win[k];
    for (int e = 0; e < NXCH; e++) begin
      if (XSTG[e] == STG) begin
        nxt[XLO[e]] = lo_w[e];
        nxt[XHI[e]] = hi_w[e];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  if (KEEP_ALL) begin : g_all
    always_ff @(posedge clk_i) begin
      for (int k = 0; k < NPIX; k++) pix_o[k*PIX_W +: PIX_W] <= nxt[k];
    end
  end else begin : g_mid
    always_ff @(posedge clk_i) pix_o <= nxt[MID];
  end
endmodule

// File: rtl/median9_net.sv
`timescale 1ns/1ps
module median9_net
  import median9_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  localparam int unsigned BUS_W = NPIX * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_vld_i,
  input  logic [BUS_W-1:0] win_pix_i,
  output logic             med_vld_o,
  output logic [PIX_W-1:0] med_pix_o
);
  logic [BUS_W-1:0] pix_c [NSTG];
  logic             vld_c [NSTG+1];

  assign pix_c[0] = win_pix_i;
  assign vld_c[0] = win_vld_i;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    if (s < NSTG - 1) begin : g_mid
      median9_stage #(.PIX_W(PIX_W), .STG(s), .KEEP_ALL(1'b1)) u_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (vld_c[s]),
        .pix_i  (pix_c[s]),
        .vld_o  (vld_c[s+1]),
        .pix_o  (pix_c[s+1])
      );
    end else begin : g_last
      median9_stage #(.PIX_W(PIX_W), .STG(s), .KEEP_ALL(1'b0)) u_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (vld_c[s]),
        .pix_i  (pix_c[s]),
        .vld_o  (vld_c[s+1]),
        .pix_o  (med_pix_o)
      );
    end
  end

  assign med_vld_o = vld_c[NSTG];
endmodule

// File: rtl/median9_net_chk.sv
`timescale 1ns/1ps
module median9_net_chk
  import median9_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  localparam int unsigned BUS_W = NPIX * PIX_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             win_vld_i,
  input logic [BUS_W-1:0] win_pix_i,
  input logic             med_vld_o,
  input logic [PIX_W-1:0] med_pix_o
);
  logic             vd [NSTG];
  logic [BUS_W-1:0] pd [NSTG];
  logic [PIX_W-1:0] mn, mx;
  int unsigned      n_lt, n_gt;
  logic             all_eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSTG; i++) vd[i] <= 1'b0;
    end else begin
      vd[0] <= win_vld_i;
      for (int i = 1; i < NSTG; i++) vd[i] <= vd[i-1];
    end
  end

  always_ff @(posedge clk_i) begin
    pd[0] <= win_pix_i;
    for (int i = 1; i < NSTG; i++) pd[i] <= pd[i-1];
  end

  always_comb begin
    logic [PIX_W-1:0] v;
    mn = pd[NSTG-1][PIX_W-1:0];
    mx = mn;
    n_lt = 0;
    n_gt = 0;
    all_eq = 1'b1;
    for (int k = 0; k < NPIX; k++) begin
      v = pd[NSTG-1][k*PIX_W +: PIX_W];
      if (v < mn) mn = v;
      if (v > mx) mx = v;
      if (v < med_pix_o) n_lt++;
      if (v > med_pix_o) n_gt++;
      if (v != pd[NSTG-1][PIX_W-1:0]) all_eq = 1'b0;
    end
  end

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    med_vld_o == vd[NSTG-1]);

  p_rank_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    med_vld_o |-> (n_lt <= MID && n_gt <= MID));

  p_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    med_vld_o |-> (med_pix_o >= mn && med_pix_o <= mx));

  p_uniform_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (med_vld_o && all_eq) |-> med_pix_o == pd[NSTG-1][PIX_W-1:0]);

  p_bubble_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vd[NSTG-1] |-> !med_vld_o);
endmodule

bind median9_net median9_net_chk #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/median9_net_tb.sv
`timescale 1ns/1ps
module median9_net_tb;
  localparam int unsigned W   = 8;
  localparam int unsigned LAT = 9;

  typedef struct {
    logic [W-1:0] val;
    int           due;
    string        req;
  } exp_t;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           win_vld_i = 1'b0;
  logic [9*W-1:0] win_pix_i = '0;
  logic           med_vld_o;
  logic [W-1:0]   med_pix_o;

  int    cyc = 0;
  int    n_run = 0;
  int    n_fail = 0;
  exp_t  sb [$];
  string quiet_req = "R7";

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  median9_net #(.PIX_W(W)) u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_vld_i (win_vld_i),
    .win_pix_i (win_pix_i),
    .med_vld_o (med_vld_o),
    .med_pix_o (med_pix_o)
  );

  function automatic logic [W-1:0] ref_med(input logic [W-1:0] p [9]);
    logic [W-1:0] s [9];
    logic [W-1:0] t;
    s = p;
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 8 - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    return s[4];
  endfunction

  task automatic send(input logic [W-1:0] p [9], input string req);
    exp_t e;
    @(negedge clk_i);
    for (int k = 0; k < 9; k++) win_pix_i[k*W +: W] = p[k];
    win_vld_i = 1'b1;
    e.val = ref_med(p);
    e.due = cyc + LAT;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      win_vld_i = 1'b0;
      win_pix_i = {9{8'hA5}};
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && med_vld_o) begin
      if (sb.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL %s: unexpected valid, got med=%0d expected no result", quiet_req, med_pix_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        n_run++;
        if (med_pix_o !== e.val) begin
          n_fail++;
          $display("FAIL %s: median got %0d expected %0d", e.req, med_pix_o, e.val);
        end
        n_run++;
        if (cyc != e.due) begin
          n_fail++;
          $display("FAIL R3: result cycle got %0d expected %0d", cyc, e.due);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] p [9];
    repeat (3) @(negedge clk_i);
    // R6: reset state
    n_run++;
    if (med_vld_o !== 1'b0) begin
      n_fail++; $display("FAIL R6: valid during reset got %0b expected 0", med_vld_o);
    end
    rst_ni = 1'b1;
    idle(2);
    n_run++;
    if (med_vld_o !== 1'b0) begin
      n_fail++; $display("FAIL R6: valid after reset got %0b expected 0", med_vld_o);
    end

    // R1: ascending, descending, scrambled
    p = '{10, 20, 30, 40, 50, 60, 70, 80, 90};   send(p, "R1");
    p = '{90, 80, 70, 60, 50, 40, 30, 20, 10};   send(p, "R1");
    p = '{33, 7, 250, 12, 99, 4, 180, 61, 45};   send(p, "R1");
    idle(LAT + 2);

    // R2: unsigned extremes
    p = '{255, 0, 128, 129, 127, 250, 3, 200, 90};  send(p, "R2");
    p = '{255, 255, 255, 255, 255, 0, 0, 0, 0};     send(p, "R2");
    p = '{0, 0, 0, 0, 128, 255, 255, 255, 255};     send(p, "R2");
    idle(3);

    // R5: duplicates
    p = '{77, 77, 77, 77, 77, 77, 77, 77, 77};   send(p, "R5");
    p = '{5, 9, 5, 9, 5, 9, 5, 9, 1};            send(p, "R5");
    p = '{200, 3, 3, 3, 200, 200, 3, 200, 100};  send(p, "R5");
    idle(LAT + 2);

    // R4: back-to-back random stream, R7: with bubbles
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < 9; k++) p[k] = W'($urandom_range(0, 255));
      send(p, "R4");
    end
    for (int i = 0; i < 30; i++) begin
      for (int k = 0; k < 9; k++) p[k] = W'($urandom_range(0, 15));
      send(p, "R7");
      if (i % 3 == 0) idle(i % 4 + 1);
    end
    idle(LAT + 3);

    // R6: reset with windows in flight
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 9; k++) p[k] = W'($urandom_range(0, 255));
      send(p, "R6");
    end
    @(negedge clk_i);
    win_vld_i = 1'b0;
    rst_ni = 1'b0;
    sb.delete();
    quiet_req = "R6";
    n_run++;
    if (med_vld_o !== 1'b0) begin
      n_fail++; $display("FAIL R6: valid in reset got %0b expected 0", med_vld_o);
    end
    idle(2);
    rst_ni = 1'b1;
    idle(LAT + 4);
    quiet_req = "R7";

    p = '{1, 2, 3, 4, 5, 6, 7, 8, 9};  send(p, "R1");
    idle(LAT + 3);

    n_run++;
    if (sb.size() != 0) begin
      n_fail++; $display("FAIL R4: pending results got %0d expected 0", sb.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule